// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block sits between one processor and the shared memory bus of a small multiprocessor. It holds a direct-mapped array of one-word lines, each with a tag and a valid bit and no other state. Loads that hit return data without touching the bus. Loads that miss win the bus, read the word from main memory, and fill the line. Every store wins the bus and writes through to main memory. A store that hits also updates the local copy. A store that misses leaves the array alone, so the cache does not allocate on writes.

Coherence uses two states per line, valid and invalid. A store by this processor appears on the shared bus as a write. Every other cache sees that write on its snoop port and drops any line that holds the same address. The next load of that address in those caches misses and fetches the fresh word from memory. The processor stalls on a bus operation until the grant arrives and memory acknowledges the transfer. Arbitration between the agents is done outside the block.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid and `cpu_ready`, `bus_req` and `bus_cmd_valid` are low, so the first load of any address goes to the bus.
- R2: A load that hits raises `cpu_ready` for exactly one cycle, two cycles after the request is taken, with the cached word on `cpu_rdata`, and never raises `bus_req`.
- R3: The line index is the low `$clog2(LINES)` bits of the word address and the tag is the remaining upper bits. A load that misses reads that address from memory, returns the memory word, and marks the line valid with the new tag, so a repeat load hits.
- R4: A load, whether it hits or misses, never issues a bus write (`bus_cmd_we` stays 0 on its command).
- R5: No bus command is issued, or held, unless `bus_gnt` is high.
- R6: Every store issues exactly one bus write carrying its address and data, whether it hits or misses.
- R7: A store that hits also updates the local line, so a later load hits and returns the stored word.
- R8: A store that misses leaves the line array unchanged (no write allocate), so a later load of that address misses.
- R9: A foreign write on the snoop port whose address matches a valid line clears that line in the same clock edge. The next local load then misses and returns the word now in memory.
- R10: A foreign write to the same index with a different tag leaves the line valid.
- R11: A bus operation holds its command until `mem_ack`, and `cpu_ready` rises only after that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_cmd_valid | output | 1 | Command on the bus |
| bus_cmd_we | output | 1 | 1 = memory write, 0 = memory read |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_wdata | output | DATA_W | Command write data |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| snp_valid | input | 1 | A foreign agent's write has completed on the bus |
| snp_addr | input | ADDR_W | Address of that foreign write |

## Verification
The assertions check on every cycle the rules that hold between neighbouring cycles. Commands appear only under grant and are held until acknowledged. Reads never put a write on the bus. A read hit completes without a bus request. A snoop match clears its line at the next edge, and a snoop with a mismatched tag leaves the line valid. What only the scenarios can show involves two caches on one bus and memory contents over several transactions. One processor's store must make the other's next load miss and fetch the fresh word. A write miss must leave a later load still missing. When two stores contend, the lower-priority cache must wait its turn and both words must reach memory.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_ARB,
    ST_WAIT,
    ST_RESP
  } wtc_state_e;
endpackage

// File: rtl/wtc_lines.sv
module wtc_lines #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  input  logic              wr_en,
  input  logic              wr_fill,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              snp_en,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_hit
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  assign lk_hit  = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign snp_hit = snp_en && valid_q[snp_idx] && (tag_mem[snp_idx] == snp_tag);

  // valid bits: the snoop clear is applied last so it wins over a fill
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (wr_en && wr_fill) valid_q[wr_idx] <= 1'b1;
      if (snp_hit)          valid_q[snp_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_fill) tag_mem[wr_idx] <= wr_tag;
  end

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) data_mem[wr_idx] <= wr_data;
    rd_data <= data_mem[rd_idx];
  end

  AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (rst)
    snp_hit |=> !valid_q[$past(snp_idx)]); // R9
  AST_SNOOP_MISMATCH_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (snp_en && valid_q[snp_idx] && (tag_mem[snp_idx] != snp_tag))
      |=> valid_q[$past(snp_idx)]); // R10
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_fill && !(snp_hit && snp_idx == wr_idx))
      |=> valid_q[$past(wr_idx)]); // R3
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic              bus_cmd_we,
  output logic [ADDR_W-1:0] bus_cmd_addr,
  output logic [DATA_W-1:0] bus_cmd_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  output logic              wr_en,
  output logic              wr_fill,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);
  wtc_state_e        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              bus_done;

  assign bus_done = (state_q == ST_WAIT) && mem_ack;

  assign rd_idx  = cpu_addr[IDX_W-1:0];
  assign lk_idx  = req_addr_q[IDX_W-1:0];
  assign lk_tag  = req_addr_q[ADDR_W-1:IDX_W];
  assign wr_en   = bus_done && (!req_we_q || lk_hit);
  assign wr_fill = !req_we_q;
  assign wr_idx  = lk_idx;
  assign wr_tag  = lk_tag;
  assign wr_data = req_we_q ? req_wdata_q : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      req_addr_q    <= '0;
      req_we_q      <= 1'b0;
      req_wdata_q   <= '0;
      cpu_rdata     <= '0;
      cpu_ready     <= 1'b0;
      bus_req       <= 1'b0;
      bus_cmd_valid <= 1'b0;
      bus_cmd_we    <= 1'b0;
      bus_cmd_addr  <= '0;
      bus_cmd_wdata <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            req_addr_q  <= cpu_addr;
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (!req_we_q && lk_hit) begin
            cpu_rdata <= rd_data;
            cpu_ready <= 1'b1;
            state_q   <= ST_RESP;
          end else begin
            bus_req <= 1'b1;
            state_q <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (bus_gnt) begin
            bus_cmd_valid <= 1'b1;
            bus_cmd_we    <= req_we_q;
            bus_cmd_addr  <= req_addr_q;
            bus_cmd_wdata <= req_wdata_q;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_ack) begin
            bus_cmd_valid <= 1'b0;
            bus_cmd_we    <= 1'b0;
            bus_req       <= 1'b0;
            cpu_ready     <= 1'b1;
            if (!req_we_q) cpu_rdata <= mem_rdata;
            state_q       <= ST_RESP;
          end
        end
        default: begin
          cpu_ready <= 1'b0;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end

  AST_CMD_UNDER_GNT: assert property (@(posedge clk) disable iff (rst)
    bus_cmd_valid |-> bus_gnt); // R5
  AST_READ_NEVER_WRITES: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_valid && !req_we_q) |-> !bus_cmd_we); // R4
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd_valid && !mem_ack) |=> bus_cmd_valid); // R11
  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && $past(state_q) == ST_WAIT) |-> $past(mem_ack)); // R11
  AST_HIT_SKIPS_BUS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && !req_we_q && lk_hit) |=> (cpu_ready && !bus_req)); // R2
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R2
  AST_STORE_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && req_we_q) |=> (bus_req && !cpu_ready)); // R6
  AST_STORE_HIT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (bus_done && req_we_q && lk_hit) |=> lk_hit); // R7
  AST_STORE_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (bus_done && req_we_q && !lk_hit) |=> !lk_hit); // R8
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_cmd_valid,
  output logic              bus_cmd_we,
  output logic [ADDR_W-1:0] bus_cmd_addr,
  output logic [DATA_W-1:0] bus_cmd_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  rd_idx, lk_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              lk_hit, wr_en, wr_fill, snp_hit;

  wtc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd_we(bus_cmd_we),
    .bus_cmd_addr(bus_cmd_addr), .bus_cmd_wdata(bus_cmd_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .wr_en(wr_en), .wr_fill(wr_fill), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  wtc_lines #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_lines (
    .clk(clk), .rst(rst),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .wr_en(wr_en), .wr_fill(wr_fill), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
    .snp_en(snp_valid), .snp_idx(snp_addr[IDX_W-1:0]), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .snp_hit(snp_hit)
  );
endmodule

// File: tb/tb_wt_snoop_cache.sv
`timescale 1ns/1ps
module tb_wt_snoop_cache;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cpu_req   [2];
  logic          cpu_we    [2];
  logic [AW-1:0] cpu_addr  [2];
  logic [DW-1:0] cpu_wdata [2];
  logic [DW-1:0] cpu_rdata [2];
  logic          cpu_ready [2];
  logic          bus_req   [2];
  logic          bus_gnt   [2];
  logic          cmd_valid [2];
  logic          cmd_we    [2];
  logic [AW-1:0] cmd_addr  [2];
  logic [DW-1:0] cmd_wdata [2];
  logic          mem_ack   [2];
  logic          snp_v     [2];
  logic [AW-1:0] snp_a     [2];
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int ack_cnt [2];
  int wr_cnt  [2];

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]),
    .cpu_rdata(cpu_rdata[0]), .cpu_ready(cpu_ready[0]),
    .bus_req(bus_req[0]), .bus_gnt(bus_gnt[0]),
    .bus_cmd_valid(cmd_valid[0]), .bus_cmd_we(cmd_we[0]),
    .bus_cmd_addr(cmd_addr[0]), .bus_cmd_wdata(cmd_wdata[0]),
    .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata),
    .snp_valid(snp_v[0]), .snp_addr(snp_a[0])
  );

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) peer (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]),
    .cpu_rdata(cpu_rdata[1]), .cpu_ready(cpu_ready[1]),
    .bus_req(bus_req[1]), .bus_gnt(bus_gnt[1]),
    .bus_cmd_valid(cmd_valid[1]), .bus_cmd_we(cmd_we[1]),
    .bus_cmd_addr(cmd_addr[1]), .bus_cmd_wdata(cmd_wdata[1]),
    .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata),
    .snp_valid(snp_v[1]), .snp_addr(snp_a[1])
  );

  // fixed-priority arbiter, agent 0 first, grant held until request drops
  logic own_vld, own;
  always @(posedge clk) begin
    if (rst) begin
      own_vld <= 1'b0; own <= 1'b0;
    end else if (own_vld) begin
      if (!bus_req[own]) own_vld <= 1'b0;
    end else if (bus_req[0]) begin
      own_vld <= 1'b1; own <= 1'b0;
    end else if (bus_req[1]) begin
      own_vld <= 1'b1; own <= 1'b1;
    end
  end

  // memory model: acknowledge after a fixed wait
  logic [DW-1:0] mem [1024];
  logic          ack_q;
  int            lat;
  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return {22'h2A5C31, a} ^ 32'h0F0F0000;
  endfunction
  initial for (int i = 0; i < 1024; i++) mem[i] = init_val(AW'(i));

  always @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0; lat <= 0; mem_rdata <= '0;
      ack_cnt[0] <= 0; ack_cnt[1] <= 0; wr_cnt[0] <= 0; wr_cnt[1] <= 0;
    end else if (ack_q) begin
      ack_q <= 1'b0; lat <= 0;
    end else if (own_vld && cmd_valid[own]) begin
      if (lat == 2) begin
        ack_q <= 1'b1;
        mem_rdata <= mem[cmd_addr[own]];
        if (cmd_we[own]) begin
          mem[cmd_addr[own]] <= cmd_wdata[own];
          wr_cnt[own] <= wr_cnt[own] + 1;
        end
        ack_cnt[own] <= ack_cnt[own] + 1;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      bus_gnt[p] = own_vld && (own == p[0]);
      mem_ack[p] = ack_q && own_vld && (own == p[0]);
    end
    snp_v[0] = ack_q && own_vld && own && cmd_we[1];
    snp_a[0] = cmd_addr[1];
    snp_v[1] = ack_q && own_vld && !own && cmd_we[0];
    snp_a[1] = cmd_addr[0];
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input int p, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q, output int cyc, output int nack, output int nwr);
    int a0 = ack_cnt[p];
    int w0 = wr_cnt[p];
    @(negedge clk);
    cpu_req[p] = 1'b1; cpu_we[p] = we; cpu_addr[p] = a; cpu_wdata[p] = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready[p] && cyc < 200);
    q = cpu_rdata[p];
    cpu_req[p] = 1'b0;
    nack = ack_cnt[p] - a0;
    nwr  = wr_cnt[p] - w0;
    if (cyc >= 200) chk(1'b0, "R11 op timeout", DW'(cyc), 32'd200);
  endtask

  logic [DW-1:0] q;
  int cyc, na, nw;

  task automatic t_reset();
    chk(!cpu_ready[0] && !cpu_ready[1], "R1 ready low", DW'(cpu_ready[0]), 0);
    chk(!bus_req[0] && !bus_req[1], "R1 bus_req low", DW'(bus_req[0]), 0);
    chk(!cmd_valid[0] && !cmd_valid[1], "R1 cmd_valid low", DW'(cmd_valid[0]), 0);
    cpu_op(0, 1'b0, 10'h023, '0, q, cyc, na, nw);
    chk(na == 1, "R1 R3 first load misses", DW'(na), 1);
    chk(nw == 0, "R4 miss issues no write", DW'(nw), 0);
    chk(q == init_val(10'h023), "R3 refill data", q, init_val(10'h023));
  endtask

  task automatic t_read_hit();
    cpu_op(0, 1'b0, 10'h023, '0, q, cyc, na, nw);
    chk(na == 0, "R2 R3 repeat load hits", DW'(na), 0);
    chk(cyc == 2, "R2 hit latency", DW'(cyc), 2);
    chk(q == init_val(10'h023), "R2 hit data", q, init_val(10'h023));
    chk(nw == 0, "R4 hit issues no write", DW'(nw), 0);
  endtask

  task automatic t_write_hit();
    cpu_op(0, 1'b1, 10'h023, 32'hDEAD0001, q, cyc, na, nw);
    chk(nw == 1, "R6 store hit writes bus", DW'(nw), 1);
    chk(mem[10'h023] == 32'hDEAD0001, "R6 memory updated", mem[10'h023], 32'hDEAD0001);
    chk(cyc > 4, "R11 store stalls for bus", DW'(cyc), 5);
    cpu_op(0, 1'b0, 10'h023, '0, q, cyc, na, nw);
    chk(na == 0, "R7 load after store hit stays local", DW'(na), 0);
    chk(q == 32'hDEAD0001, "R7 local copy updated", q, 32'hDEAD0001);
  endtask

  task automatic t_write_miss();
    cpu_op(0, 1'b1, 10'h155, 32'hBEEF0002, q, cyc, na, nw);
    chk(nw == 1, "R6 store miss writes bus", DW'(nw), 1);
    chk(mem[10'h155] == 32'hBEEF0002, "R6 memory updated on miss", mem[10'h155], 32'hBEEF0002);
    cpu_op(0, 1'b0, 10'h155, '0, q, cyc, na, nw);
    chk(na == 1, "R8 no allocate: load misses", DW'(na), 1);
    chk(q == 32'hBEEF0002, "R8 load returns memory word", q, 32'hBEEF0002);
  endtask

  task automatic t_snoop_match();
    cpu_op(1, 1'b0, 10'h023, '0, q, cyc, na, nw);
    chk(q == 32'hDEAD0001, "R3 peer refill", q, 32'hDEAD0001);
    cpu_op(1, 1'b0, 10'h023, '0, q, cyc, na, nw);
    chk(na == 0, "R3 peer hit before snoop", DW'(na), 0);
    cpu_op(0, 1'b1, 10'h023, 32'h1234ABCD, q, cyc, na, nw);
    cpu_op(1, 1'b0, 10'h023, '0, q, cyc, na, nw);
    chk(na == 1, "R9 snooped line misses", DW'(na), 1);
    chk(q == 32'h1234ABCD, "R9 fresh value fetched", q, 32'h1234ABCD);
  endtask

  task automatic t_snoop_other_tag();
    cpu_op(1, 1'b0, 10'h047, '0, q, cyc, na, nw);
    cpu_op(0, 1'b1, 10'h0C7, 32'h0BADF00D, q, cyc, na, nw);
    cpu_op(1, 1'b0, 10'h047, '0, q, cyc, na, nw);
    chk(na == 0, "R10 different tag kept valid", DW'(na), 0);
    chk(q == init_val(10'h047), "R10 data intact", q, init_val(10'h047));
  endtask

  task automatic t_contend();
    logic [DW-1:0] q0, q1;
    int c0, c1, a0, a1, w0, w1;
    fork
      cpu_op(0, 1'b1, 10'h200, 32'hAAAA5555, q0, c0, a0, w0);
      cpu_op(1, 1'b1, 10'h201, 32'h5555AAAA, q1, c1, a1, w1);
    join
    chk(c0 < c1, "R5 R11 lower priority waits for grant", DW'(c1), DW'(c0 + 1));
    chk(w0 == 1 && w1 == 1, "R6 both stores reach bus", DW'(w1), 1);
    chk(mem[10'h200] == 32'hAAAA5555, "R6 first word", mem[10'h200], 32'hAAAA5555);
    chk(mem[10'h201] == 32'h5555AAAA, "R6 second word", mem[10'h201], 32'h5555AAAA);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      cpu_req[p] = 1'b0; cpu_we[p] = 1'b0; cpu_addr[p] = '0; cpu_wdata[p] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_snoop_match();
    t_snoop_other_tag();
    t_contend();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 20000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule